// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds two 64-bit operands as a packed vector of independent integer lanes. A 2-bit lane-size select splits the operands into eight byte lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane, and the carry chain is cut at every lane edge. A 2-bit mode select picks the arithmetic: wrap-around, unsigned saturation or signed saturation. A lane that overflows in a saturating mode clamps to its limit instead of wrapping.

Each accepted operation is registered once. The result and an 8-bit per-byte overflow vector appear one clock after the input strobe, together with an output strobe. Lane size and mode can change on every operation, so a datapath that issues mixed-width packed adds can feed this block back to back.

Top module: `simd_sat_add`

## Requirements
- R1: Lane size select encodes 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and 11 = 64-bit lanes. Lane k covers bits [k*W+W-1 : k*W] for lane width W, and no carry passes from one lane into the next.
- R2: Mode 00 (wrap) gives each lane its sum modulo 2^W. Mode 11 behaves exactly like mode 00.
- R3: Mode 01 (unsigned saturate) gives the all-ones value of the lane (0xFF, 0xFFFF, and so on) when the unsigned lane sum exceeds 2^W-1. Otherwise it gives the plain sum.
- R4: Mode 10 (signed saturate) treats lanes as two's complement. A positive overflow clamps the lane to its most positive value (0x7F... pattern) and a negative overflow clamps it to its most negative value (0x80... pattern). Otherwise it gives the plain sum.
- R5: out_ovf has one bit per byte, with bit j covering result bits [8j+7:8j]. Every byte bit of a lane carries that lane's overflow indication. In modes 00, 01 and 11 this indication is the unsigned carry out of the lane. In mode 10 it is signed overflow.
- R6: An operation presented with in_valid high yields out_valid high with its result and flags on the next clock. A cycle with in_valid low gives out_valid low on the next clock and leaves out_sum and out_ovf unchanged, whatever the other inputs carry.
- R7: A clock edge with rst high clears out_valid, out_sum and out_ovf to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_lane_size | input | 2 | Lane size select (R1 encoding) |
| in_mode | input | 2 | Arithmetic mode select |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_sum | output | 64 | Packed result |
| out_ovf | output | 8 | Per-byte overflow flags |

## Verification
In byte lanes, a dense sweep over operand pairs runs under each mode. Each byte position sees a different pair, so a wrong clamp value or a carry leaking between bytes shows up against the arithmetic model. Operands built only from the boundary bytes 00, 01, 7F, 80, FE and FF run under every lane size and mode. These separate carry cuts at 16/32/64-bit edges, the positive and negative signed limits, and flag replication across a lane. Uniform random operands add general coverage. Directed cases pin literal results for the carry cut, for mode 11 matching wrap, and for outputs holding while in_valid is low and after reset.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
   typedef enum logic [1:0] {
      LSZ_B8  = 2'b00,
      LSZ_B16 = 2'b01,
      LSZ_B32 = 2'b10,
      LSZ_B64 = 2'b11
   } lane_size_e;

   typedef enum logic [1:0] {
      AM_WRAP = 2'b00,
      AM_USAT = 2'b01,
      AM_SSAT = 2'b10,
      AM_RSVD = 2'b11
   } add_mode_e;

   // byte-index mask selecting the bytes inside one lane
   function automatic logic [2:0] lane_mask(input lane_size_e sz);
      case (sz)
         LSZ_B8:  lane_mask = 3'b000;
         LSZ_B16: lane_mask = 3'b001;
         LSZ_B32: lane_mask = 3'b011;
         default: lane_mask = 3'b111;
      endcase
   endfunction
endpackage

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
   import simd_add_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 8,
   localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
   input  logic [DATA_W-1:0]    a,
   input  logic [DATA_W-1:0]    b,
   input  lane_size_e           lane_size,
   output logic [DATA_W-1:0]    sum,
   output logic [NUM_BYTES-1:0] cout,
   output logic [NUM_BYTES-1:0] cmsb
);
   logic [2:0] mask;
   assign mask = lane_mask(lane_size);

   // byte-sliced ripple; carry is forced to zero at each lane start
   always_comb begin
      logic              carry;
      logic [BYTE_W-1:0] lo;
      logic [1:0]        hi;
      carry = 1'b0;
      sum   = '0;
      cout  = '0;
      cmsb  = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if ((3'(i) & mask) == 3'b000) carry = 1'b0;
         lo = {1'b0, a[i*BYTE_W +: BYTE_W-1]} + {1'b0, b[i*BYTE_W +: BYTE_W-1]}
              + {{(BYTE_W-1){1'b0}}, carry};
         hi = {1'b0, a[i*BYTE_W+BYTE_W-1]} + {1'b0, b[i*BYTE_W+BYTE_W-1]}
              + {1'b0, lo[BYTE_W-1]};
         sum[i*BYTE_W +: BYTE_W] = {hi[0], lo[BYTE_W-2:0]};
         cmsb[i] = lo[BYTE_W-1];
         cout[i] = hi[1];
         carry   = hi[1];
      end
   end
endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
   import simd_add_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 8,
   localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
   input  logic [DATA_W-1:0]    sum,
   input  logic [NUM_BYTES-1:0] cout,
   input  logic [NUM_BYTES-1:0] cmsb,
   input  logic [NUM_BYTES-1:0] a_msb,
   input  lane_size_e           lane_size,
   input  add_mode_e            mode,
   output logic [DATA_W-1:0]    res,
   output logic [NUM_BYTES-1:0] flags
);
   logic [2:0] mask;
   assign mask = lane_mask(lane_size);

   always_comb begin
      logic [2:0] top;
      logic       u_ovf;
      logic       s_ovf;
      logic       neg;
      res   = sum;
      flags = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         top   = 3'(i) | mask;
         u_ovf = cout[top];
         s_ovf = cout[top] ^ cmsb[top];
         neg   = a_msb[top];
         flags[i] = (mode == AM_SSAT) ? s_ovf : u_ovf;
         if (mode == AM_USAT && u_ovf) begin
            res[i*BYTE_W +: BYTE_W] = '1;
         end else if (mode == AM_SSAT && s_ovf) begin
            if (3'(i) == top)
               res[i*BYTE_W +: BYTE_W] = {neg, {(BYTE_W-1){~neg}}};
            else
               res[i*BYTE_W +: BYTE_W] = {BYTE_W{~neg}};
         end
      end
   end
endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
   import simd_add_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 8,
   localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [DATA_W-1:0]    in_a,
   input  logic [DATA_W-1:0]    in_b,
   input  logic [1:0]           in_lane_size,
   input  logic [1:0]           in_mode,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_sum,
   output logic [NUM_BYTES-1:0] out_ovf
);
   generate
      if (NUM_BYTES != 8) begin : g_bad_bytes
         $error("simd_sat_add: the 2-bit lane select needs exactly 8 bytes");
      end
      if (BYTE_W < 2) begin : g_bad_width
         $error("simd_sat_add: BYTE_W must be at least 2");
      end
   endgenerate

   lane_size_e            sz;
   add_mode_e             md;
   logic [DATA_W-1:0]     raw_sum;
   logic [NUM_BYTES-1:0]  raw_cout;
   logic [NUM_BYTES-1:0]  raw_cmsb;
   logic [NUM_BYTES-1:0]  a_msb;
   logic [DATA_W-1:0]     sat_res;
   logic [NUM_BYTES-1:0]  sat_flags;

   assign sz = lane_size_e'(in_lane_size);
   assign md = add_mode_e'(in_mode);

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_msb
      assign a_msb[g] = in_a[g*BYTE_W + BYTE_W - 1];
   end

   simd_lane_adder #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_add (
      .a(in_a), .b(in_b), .lane_size(sz),
      .sum(raw_sum), .cout(raw_cout), .cmsb(raw_cmsb)
   );

   simd_lane_sat #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_sat (
      .sum(raw_sum), .cout(raw_cout), .cmsb(raw_cmsb), .a_msb(a_msb),
      .lane_size(sz), .mode(md), .res(sat_res), .flags(sat_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_sum   <= '0;
         out_ovf   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sum <= sat_res;
            out_ovf <= sat_flags;
         end
      end
   end
endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 8,
   localparam int DATA_W   = BYTE_W * NUM_BYTES
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [DATA_W-1:0]    in_a,
   input logic [DATA_W-1:0]    in_b,
   input logic [1:0]           in_lane_size,
   input logic [1:0]           in_mode,
   input logic                 out_valid,
   input logic [DATA_W-1:0]    out_sum,
   input logic [NUM_BYTES-1:0] out_ovf
);
   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (!out_valid && out_ovf == '0 && out_sum == '0));

   p_valid_next_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_sum) && $stable(out_ovf)));

   p_wrap64_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_lane_size == 2'b11 && (in_mode == 2'b00 || in_mode == 2'b11))
      |=> out_sum == $past(in_a + in_b));

   p_flag_pairs_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_lane_size == 2'b01)
      |=> (out_ovf[0] == out_ovf[1] && out_ovf[2] == out_ovf[3] &&
           out_ovf[4] == out_ovf[5] && out_ovf[6] == out_ovf[7]));

   p_flag_whole_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_lane_size == 2'b11)
      |=> (out_ovf == '0 || (&out_ovf)));

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
      p_usat_ones_r3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_mode == 2'b01)
         |=> (!out_ovf[g] || (&out_sum[g*BYTE_W +: BYTE_W])));

      p_ssat_limit_r4: assert property (@(posedge clk) disable iff (rst)
         (in_valid && in_mode == 2'b10 && in_lane_size == 2'b00)
         |=> (!out_ovf[g] ||
              out_sum[g*BYTE_W +: BYTE_W] == {1'b0, {(BYTE_W-1){1'b1}}} ||
              out_sum[g*BYTE_W +: BYTE_W] == {1'b1, {(BYTE_W-1){1'b0}}}));
   end
endmodule

bind simd_sat_add simd_sat_add_chk #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
   .in_lane_size(in_lane_size), .in_mode(in_mode), .out_valid(out_valid),
   .out_sum(out_sum), .out_ovf(out_ovf)
);

// File: tb/sim_simd_sat_add.sv
module sim_simd_sat_add;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic [1:0]  in_lane_size = 2'b00;
   logic [1:0]  in_mode = 2'b00;
   logic        out_valid;
   logic [63:0] out_sum;
   logic [7:0]  out_ovf;

   int total = 0;
   int bad   = 0;
   logic [63:0] last_sum;
   logic [7:0]  last_ovf;

   always #5 clk = ~clk;

   simd_sat_add u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_lane_size(in_lane_size), .in_mode(in_mode), .out_valid(out_valid),
      .out_sum(out_sum), .out_ovf(out_ovf)
   );

   // lane-by-lane arithmetic model
   function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [1:0] sz, input logic [1:0] md,
                                 output logic [63:0] r, output logic [7:0] f);
      int w;
      int nl;
      logic [64:0] mask, ua, ub, s, lane;
      logic uo, so, sa, sb, sm, ov;
      w  = 8 << sz;
      nl = 64 / w;
      r  = '0;
      f  = '0;
      mask = (65'd1 << w) - 65'd1;
      for (int l = 0; l < nl; l++) begin
         ua = ({1'b0, a} >> (l * w)) & mask;
         ub = ({1'b0, b} >> (l * w)) & mask;
         s  = ua + ub;
         uo = s[w];
         sa = ua[w-1];
         sb = ub[w-1];
         sm = s[w-1];
         so = (sa == sb) && (sm != sa);
         lane = s & mask;
         if (md == 2'b01 && uo) lane = mask;
         if (md == 2'b10 && so) lane = sa ? (65'd1 << (w - 1)) : (mask >> 1);
         ov = (md == 2'b10) ? so : uo;
         r = r | (lane[63:0] << (l * w));
         for (int j = 0; j < w / 8; j++) f[l * (w / 8) + j] = ov;
      end
   endfunction

   task automatic check(input string tag, input logic ok, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                      input logic [1:0] md, input string tag);
      logic [63:0] er;
      logic [7:0]  ef;
      model(a, b, sz, md, er, ef);
      @(negedge clk);
      in_a = a; in_b = b; in_lane_size = sz; in_mode = md; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " valid"}, out_valid == 1'b1, {63'd0, out_valid}, 64'd1);
      check({tag, " sum"}, out_sum == er, out_sum, er);
      check({tag, " flags"}, out_ovf == ef, {56'd0, out_ovf}, {56'd0, ef});
      last_sum = out_sum;
      last_ovf = out_ovf;
   endtask

   function automatic logic [7:0] edge_byte(input int k);
      case (k % 6)
         0: edge_byte = 8'h00;
         1: edge_byte = 8'h01;
         2: edge_byte = 8'h7F;
         3: edge_byte = 8'h80;
         4: edge_byte = 8'hFE;
         default: edge_byte = 8'hFF;
      endcase
   endfunction

   initial begin
      #1_900_000;
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] va, vb;
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 reset valid", out_valid == 1'b0, {63'd0, out_valid}, 64'd0);
      check("R7 reset sum", out_sum == 64'd0, out_sum, 64'd0);
      check("R7 reset flags", out_ovf == 8'd0, {56'd0, out_ovf}, 64'd0);
      rst = 1'b0;

      // directed literals
      run(64'h00000000000000FF, 64'h0000000000000001, 2'b01, 2'b00, "R1 carry inside 16-bit lane");
      check("R1 literal", out_sum == 64'h0000000000000100, out_sum, 64'h0000000000000100);
      run(64'h00000000000000FF, 64'h0000000000000001, 2'b00, 2'b00, "R1 carry cut byte");
      check("R1 cut literal", out_sum == 64'h0, out_sum, 64'h0);
      check("R5 wrap carry flag", out_ovf == 8'h01, {56'd0, out_ovf}, 64'h01);
      run(64'hFFFFFFFFFFFFFFFF, 64'h1, 2'b11, 2'b00, "R2 wrap 64");
      check("R5 whole-lane flags", out_ovf == 8'hFF, {56'd0, out_ovf}, 64'hFF);
      run(64'hFFFFFFFFFFFFFFFF, 64'h1, 2'b11, 2'b11, "R2 mode 11 as wrap");
      check("R2 mode 11 literal", out_sum == 64'h0, out_sum, 64'h0);
      run(64'h00000000000000F0, 64'h0000000000000020, 2'b00, 2'b01, "R3 byte saturate");
      check("R3 literal FF", out_sum == 64'hFF, out_sum, 64'hFF);
      run(64'h000000000000FFF0, 64'h0000000000000020, 2'b01, 2'b01, "R3 16-bit saturate");
      check("R3 literal FFFF", out_sum == 64'hFFFF, out_sum, 64'hFFFF);
      run(64'h0000000000007FFF, 64'h0000000000000001, 2'b01, 2'b10, "R4 positive clamp");
      check("R4 literal 7FFF", out_sum == 64'h7FFF, out_sum, 64'h7FFF);
      run(64'h0000000080000000, 64'h00000000FFFFFFFF, 2'b10, 2'b10, "R4 negative clamp");
      check("R4 literal 80000000", out_sum == 64'h80000000, out_sum, 64'h80000000);

      // R6 idle cycles ignore changed inputs
      @(negedge clk);
      in_a = 64'h123456789ABCDEF0; in_b = 64'hFFFFFFFFFFFFFFFF; in_mode = 2'b01;
      @(negedge clk);
      @(negedge clk);
      check("R6 idle valid low", out_valid == 1'b0, {63'd0, out_valid}, 64'd0);
      check("R6 idle sum held", out_sum == last_sum, out_sum, last_sum);
      check("R6 idle flags held", out_ovf == last_ovf, {56'd0, out_ovf}, {56'd0, last_ovf});

      // byte-lane sweep in every defined mode
      for (int m = 0; m < 3; m++)
         for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y += 7) begin
               for (int i = 0; i < 8; i++) begin
                  va[i*8 +: 8] = 8'(x + i * 29);
                  vb[i*8 +: 8] = 8'(y + i * 71);
               end
               run(va, vb, 2'b00, 2'(m), "R1 R2 R3 R4 byte sweep");
            end

      // boundary-byte and random operands at every size and mode
      for (int s = 0; s < 4; s++)
         for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 300; k++) begin
               for (int i = 0; i < 8; i++) begin
                  va[i*8 +: 8] = edge_byte(int'($urandom_range(0, 5)));
                  vb[i*8 +: 8] = edge_byte(int'($urandom_range(0, 5)));
               end
               run(va, vb, 2'(s), 2'(m), "R1 R4 R5 boundary lanes");
            end
            for (int k = 0; k < 300; k++)
               run({$urandom, $urandom}, {$urandom, $urandom}, 2'(s), 2'(m),
                   "R2 R3 R5 random lanes");
         end

      // R7 reset after activity
      run(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'b00, 2'b01, "R3 pre-reset");
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R7 mid reset valid", out_valid == 1'b0, {63'd0, out_valid}, 64'd0);
      check("R7 mid reset sum", out_sum == 64'd0, out_sum, 64'd0);
      check("R7 mid reset flags", out_ovf == 8'd0, {56'd0, out_ovf}, 64'd0);
      rst = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule